// File: doc/BRIEF.md
# Chip-Select Serial Readout Port for an 18-bit SAR Converter

This block is a synthesizable behavioural model of the digital serial port of an 18-bit successive-approximation converter. It models the 4-wire chip-select mode without a busy indicator. A parallel sample word stands in for the analog result. The host raises the convert strobe while holding the select line high. That one edge chooses the chip-select mode and starts a conversion timer, which counts system-clock cycles. While the conversion runs, the serial output is released to high impedance.

When the timer expires, the port enters its acquisition phase and stores the sample word. A falling edge on the active-low select then places the result's top bit on the serial output. Each falling edge of the serial clock after that brings out the next lower bit. The readout ends on the 18th serial-clock falling edge, or earlier if select returns high, whichever comes first. After that the output floats again, so another device can share the line.

All pins are sampled in the system-clock domain, and edges are detected from those samples. High impedance is modelled by a separate output-enable. A two-bit phase code is brought out for observation.

Top module: `sar_cs_port`

## Requirements
- R1: A rising edge on `cnv` while `sel_n` is high starts a conversion. `phase` becomes 1 (converting) and `sdo_oe` is 0 for as long as the conversion lasts.
- R2: While `phase` is 0 (idle), if `cnv` and `sel_n` are both low, then `sdo_oe` is 1 and `sdo` is 0.
- R3: A conversion lasts `CONV_CYCLES` system-clock cycles. After that `phase` becomes 2 (acquisition).
- R4: `sel_n` held low across the end of a conversion does not start a readout. A readout needs a falling edge of `sel_n` while `phase` is 2.
- R5: A falling edge of `sel_n` while `phase` is 2 sets `sdo_oe` to 1 and puts bit 17 (the most significant bit) of the stored result on `sdo`.
- R6: During a readout, each falling edge of `sck` moves `sdo` to the next lower bit of the result.
- R7: After the 18th falling edge of `sck` in a readout, `sdo_oe` returns to 0.
- R8: A rising edge of `sel_n` during a readout sets `sdo_oe` to 0 at once. Pulling `sel_n` low again before the next conversion does not restart the readout.
- R9: The result is stored from `sample` when the conversion completes. Later changes on `sample` do not alter the bits that are read out.
- R10: Falling edges of `sck` during a conversion, or while `sel_n` is high before a readout, do not advance the result. The next readout still starts at bit 17.
- R11: A falling edge of `cnv` returns `phase` to 0.
- R12: A rising edge of `cnv` while `sel_n` is low does not start a conversion, and `phase` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; its rising edge starts a conversion, and it is held high through readout |
| sel_n | input | 1 | Active-low device select; also the mode strap at the `cnv` rising edge |
| sck | input | 1 | Serial clock; its falling edge advances the output bit |
| sample | input | BITS | Parallel word standing in for the analog result |
| sdo | output | 1 | Serial data, most significant bit first |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 models high impedance |
| phase | output | 2 | 0 idle, 1 converting, 2 acquisition |

## Verification
The bench builds the port with `BITS` left at 18 and `CONV_CYCLES` set to 12. The short conversion makes room for several full and partial readouts in a short run. It also lets the bench place select and serial-clock activity inside the conversion window and still reach the acquisition phase. Keeping the result at 18 bits makes the 18th-edge cutoff and the last bit of a word directly observable.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_ACQ  = 2'd2
  } phase_t;

  function automatic logic rose(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic fell(input logic now_v, input logic was_v);
    return ~now_v & was_v;
  endfunction

endpackage

// File: rtl/sar_pin_sampler.sv
module sar_pin_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] rst_val,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[i] <= rst_val[i];
        prv[i] <= rst_val[i];
      end else begin
        lvl[i] <= pins[i];
        prv[i] <= lvl[i];
      end
    end
  end

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(CYCLES - 1);
      busy <= 1'b1;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int BITS = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] word,
  input  logic            begin_rd,
  input  logic            shift,
  input  logic            stop,
  input  logic            clear,
  output logic            active,
  output logic            msb,
  output logic [$clog2(BITS)-1:0] cnt
);

  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sreg;
  logic            spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      cnt    <= '0;
      active <= 1'b0;
      spent  <= 1'b1;
    end else if (load) begin
      sreg   <= word;
      cnt    <= '0;
      active <= 1'b0;
      spent  <= 1'b0;
    end else if (clear) begin
      active <= 1'b0;
      spent  <= 1'b1;
    end else if (active) begin
      if (stop) begin
        active <= 1'b0;
        spent  <= 1'b1;
      end else if (shift) begin
        if (cnt == CW'(BITS - 1)) begin
          active <= 1'b0;
          spent  <= 1'b1;
        end else begin
          sreg <= {sreg[BITS-2:0], 1'b0};
          cnt  <= cnt + 1'b1;
        end
      end
    end else if (begin_rd && !spent) begin
      active <= 1'b1;
    end
  end

  assign msb = sreg[BITS-1];

endmodule

// File: rtl/sar_cs_port.sv
module sar_cs_port #(
  parameter int BITS        = 18,
  parameter int CONV_CYCLES = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnv,
  input  logic            sel_n,
  input  logic            sck,
  input  logic [BITS-1:0] sample,
  output logic            sdo,
  output logic            sdo_oe,
  output logic [1:0]      phase
);

  import sar_pkg::*;

  localparam int CW = $clog2(BITS);

  logic [2:0] pin_lvl, pin_prv;
  logic cnv_rise, cnv_fall, sel_rise, sel_fall, sck_fall;
  logic conv_start, conv_done, conv_abort, shift_en;
  logic t_busy, t_done, rd_active, rd_msb;
  logic [CW-1:0] bit_cnt;
  phase_t ph;

  sar_pin_sampler #(.N(3)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .pins({sck, sel_n, cnv}),
    .rst_val(3'b010),
    .lvl(pin_lvl), .prv(pin_prv)
  );

  assign cnv_rise = rose(pin_lvl[0], pin_prv[0]);
  assign cnv_fall = fell(pin_lvl[0], pin_prv[0]);
  assign sel_rise = rose(pin_lvl[1], pin_prv[1]);
  assign sel_fall = fell(pin_lvl[1], pin_prv[1]);
  assign sck_fall = fell(pin_lvl[2], pin_prv[2]);

  assign conv_start = (ph == PH_IDLE) && cnv_rise && pin_lvl[1];
  assign conv_abort = (ph == PH_CONV) && cnv_fall;
  assign conv_done  = (ph == PH_CONV) && t_done && !cnv_fall;
  assign shift_en   = rd_active && sck_fall && !pin_lvl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else begin
      case (ph)
        PH_IDLE: if (conv_start) ph <= PH_CONV;
        PH_CONV: if (cnv_fall) ph <= PH_IDLE;
                 else if (conv_done) ph <= PH_ACQ;
        PH_ACQ:  if (cnv_fall) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  sar_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(conv_start), .abort(conv_abort),
    .busy(t_busy), .done(t_done)
  );

  sar_shift_out #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(conv_done), .word(sample),
    .begin_rd((ph == PH_ACQ) && sel_fall),
    .shift(shift_en), .stop(sel_rise), .clear(cnv_fall),
    .active(rd_active), .msb(rd_msb), .cnt(bit_cnt)
  );

  assign sdo_oe = rd_active || ((ph == PH_IDLE) && !pin_lvl[0] && !pin_lvl[1]);
  assign sdo    = rd_active & rd_msb;
  assign phase  = ph;

endmodule

// File: rtl/sar_cs_port_chk.sv
module sar_cs_port_chk #(
  parameter int BITS        = 18,
  parameter int CONV_CYCLES = 40
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              phase,
  input logic                    sdo_oe,
  input logic                    conv_start,
  input logic                    conv_done,
  input logic                    shift_en,
  input logic                    rd_active,
  input logic [$clog2(BITS)-1:0] bit_cnt
);

  logic [15:0] conv_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              conv_len <= '0;
    else if (phase != 2'd1)  conv_len <= '0;
    else                     conv_len <= conv_len + 1'b1;
  end

  AST_START_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (phase == 2'd1)); // R1
  AST_CONV_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> !sdo_oe); // R1
  AST_DONE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (phase == 2'd2)); // R3
  AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (conv_len == 16'(CONV_CYCLES - 1))); // R3
  AST_ACQ_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == 2'd2) && sdo_oe) |-> rd_active); // R5
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> (32'(bit_cnt) < BITS)); // R7
  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (rd_active && (phase == 2'd2))); // R10

endmodule

bind sar_cs_port sar_cs_port_chk #(.BITS(BITS), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .sdo_oe(sdo_oe),
  .conv_start(conv_start), .conv_done(conv_done), .shift_en(shift_en),
  .rd_active(rd_active), .bit_cnt(bit_cnt)
);

// File: tb/sim_sar_cs_port.sv
`timescale 1ns/1ps
module sim_sar_cs_port;

  localparam int BITS = 18;
  localparam int CONV = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv = 1'b0, sel_n = 1'b1, sck = 1'b0;
  logic [BITS-1:0] sample = '0;
  logic sdo, sdo_oe;
  logic [1:0] phase;

  sar_cs_port #(.BITS(BITS), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sel_n(sel_n), .sck(sck),
    .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe), .phase(phase)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic       oe;
    logic       d;
    logic [1:0] ph;
    logic       use_ph;
    string      tag;
  } exp_t;

  exp_t q[$];
  event smp;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always @(smp) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (sdo_oe !== e.oe) begin
        errors++;
        $display("FAIL %s: sdo_oe=%b expected %b", e.tag, sdo_oe, e.oe);
      end
      if (e.oe) begin
        checks++;
        if (sdo !== e.d) begin
          errors++;
          $display("FAIL %s: sdo=%b expected %b", e.tag, sdo, e.d);
        end
      end
      if (e.use_ph) begin
        checks++;
        if (phase !== e.ph) begin
          errors++;
          $display("FAIL %s: phase=%0d expected %0d", e.tag, phase, e.ph);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic oe, input logic d, input logic use_ph,
                            input logic [1:0] ph, input string tag);
    exp_t e;
    e.oe = oe; e.d = d; e.ph = ph; e.use_ph = use_ph; e.tag = tag;
    q.push_back(e);
    -> smp;
    #1;
  endtask

  task automatic sck_pulse;
    sck = 1'b1; step(3);
    sck = 1'b0; step(3);
  endtask

  task automatic start_conv(input logic [BITS-1:0] w);
    sample = w; sel_n = 1'b1; step(2);
    cnv = 1'b1; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd1, "R1 converting, output floats");
  endtask

  // Full or partial readout; the expected bits come from the word itself.
  task automatic read_word(input logic [BITS-1:0] w, input int nbits, input string tag);
    sel_n = 1'b0; step(3);
    expect_out(1'b1, w[BITS-1], 1'b1, 2'd2, {tag, " R5 msb first"});
    for (int i = 1; i < nbits; i++) begin
      sck_pulse();
      expect_out(1'b1, w[BITS-1-i], 1'b0, 2'd0, {tag, " R6 next bit"});
    end
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [BITS-1:0] wa, wb, wc;
    wa = 18'h2A5C3; wb = 18'h1B00F; wc = 18'h00001;
    step(3); rst_n = 1'b1; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd0, "reset state");

    sel_n = 1'b0; step(3);
    expect_out(1'b1, 1'b0, 1'b1, 2'd0, "R2 idle drive low");
    // R12: convert edge with select low
    cnv = 1'b1; step(3 + CONV);
    expect_out(1'b0, 1'b0, 1'b1, 2'd0, "R12 no conversion with sel low");
    cnv = 1'b0; sel_n = 1'b1; step(3);

    // Conversion A, with select and clock activity during conversion
    start_conv(wa);
    sel_n = 1'b0; sck = 1'b1; step(1); sck = 1'b0; step(1);
    step(CONV);
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R3 R4 acquisition, no readout from held-low select");
    sample = ~wa;                                  // R9
    sel_n = 1'b1; step(3);
    sck_pulse(); sck_pulse();                      // R10
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R10 sck with sel high ignored");
    read_word(wa, BITS, "R9 R10 word A");
    sck_pulse();
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R7 float after 18th falling edge");
    sel_n = 1'b1; step(3); sel_n = 1'b0; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R8 no second readout");
    cnv = 1'b0; step(3);
    expect_out(1'b1, 1'b0, 1'b1, 2'd0, "R11 R2 back to idle, drive low");
    sel_n = 1'b1; step(3);

    // Conversion B: early termination by select
    start_conv(wb);
    step(CONV + 2);
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R3 acquisition B");
    read_word(wb, 5, "word B");
    sel_n = 1'b1; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R8 sel high ends readout");
    sel_n = 1'b0; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R8 reselect does not restart");
    sel_n = 1'b1; cnv = 1'b0; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd0, "R11 idle after B");

    // Conversion C: lowest bit set
    start_conv(wc);
    step(CONV + 2);
    read_word(wc, BITS, "word C");
    sck_pulse();
    expect_out(1'b0, 1'b0, 1'b1, 2'd2, "R7 float after word C");
    sel_n = 1'b1; cnv = 1'b0; step(3);
    expect_out(1'b0, 1'b0, 1'b1, 2'd0, "R11 idle after C");
    step(2);
    finish_run();
  end

endmodule